// File: doc/BRIEF.md
# I2C Slave Serial Port with Start/Stop Detection

This block is an I2C slave for standard-mode bus timing. It is clocked by the system clock. It samples SCL and SDA through a synchronizer and finds Start and Stop conditions and clock edges in the sampled lines. Received bytes move MSb first through an internal shift register, and each acknowledged byte is copied into a buffer register that the CPU can read and write. The slave compares incoming address bytes with a programmable own address, in either 7-bit or 10-bit form. It acknowledges matches and raises an interrupt flag on every completed byte. Address 0x00, the general call, is never acknowledged.

A small register port gives access to five registers:

| Register | Offset | Contents |
|---|---|---|
| CTRL | 0 | bit 5 enable, bits 3:0 mode |
| STAT | 1 | see below |
| BUF | 2 | received or transmit byte |
| ADRL | 3 | 7-bit address in bits 6:0, or the low address byte in 10-bit mode |
| ADRH | 4 | bits 1:0 are the 10-bit high address bits |

STAT bits:

| Bit | Meaning |
|---|---|
| 0 | buffer full |
| 1 | Start seen |
| 2 | Stop seen |
| 3 | read transfer |
| 4 | last byte was data |
| 6 | clock held low |
| 7 | interrupt flag |

Writing 1 to STAT bit 7 clears the interrupt flag. Reading BUF clears buffer full. The outputs `scl_oe` and `sda_oe` are pull-low enables for open-drain pads: 1 pulls the line low and 0 releases it, so the pad never drives high.

Mode codes:

| Code | Mode |
|---|---|
| 0x1 | 7-bit slave |
| 0x2 | 10-bit slave |
| 0x5 | 7-bit slave with Start/Stop interrupts |
| 0x6 | 10-bit slave with Start/Stop interrupts |
| 0x8 | firmware-driven master: Start/Stop interrupts only, slave logic idle |

Any other code leaves the slave idle without interrupts.

Top module: `i2c_slave_port`

## Requirements
- R1: While CTRL bit 5 is 0, `sda_oe` and `scl_oe` stay 0, no byte is acknowledged, and the protocol state returns to idle.
- R2: In 7-bit modes, an address byte whose bits 7:1 equal ADRL bits 6:0 is acknowledged by pulling SDA low during the 9th clock. The byte is then loaded into BUF, and STAT bits 0 and 7 are set.
- R3: An address byte that does not match gets no acknowledge. Bytes that follow it are ignored until the next Start: SDA is not pulled low and BUF and buffer full are unchanged.
- R4: An address byte with bits 7:1 equal to zero is never acknowledged, even when ADRL is zero.
- R5: A Start sets STAT bit 1 and clears bit 2. A Stop sets bit 2 and clears bit 1. The two bits are never both 1.
- R6: Start and Stop set the interrupt flag only in modes 0x5, 0x6 and 0x8. In modes 0x1 and 0x2 they do not set it.
- R7: In mode 0x8 the slave never acknowledges any address.
- R8: In 10-bit modes, a write is addressed by a first byte 11110 h1 h0 0, where h1:h0 equal ADRH bits 1:0, followed by a byte equal to ADRL. Each of the two bytes is acknowledged only when it matches.
- R9: After a 10-bit write address has fully matched, a repeated Start followed by 11110 h1 h0 1 is acknowledged and starts a read transfer, with STAT bit 3 set.
- R10: In a read transfer the slave holds SCL low after each acknowledge clock until the CPU writes BUF. It then sends the written byte MSb first.
- R11: A master NACK after a transmitted byte ends the read transfer: SCL and SDA are released and no further stretch occurs.
- R12: A data byte received while buffer full is set is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | pull SCL low when 1 |
| sda_oe | output | 1 | pull SDA low when 1 |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe |
| reg_addr | input | 3 | register offset |
| reg_wdata | input | 8 | register write data |
| reg_rdata | output | 8 | register read data |
| irq | output | 1 | interrupt flag |

## Verification
The bench builds the block with the default two-stage synchronizer. With that setting the bus reaches the detectors three system clocks after each line change. The bench's master drives each bus phase for ten clocks, which is well above that latency. This lets it exercise acknowledge timing, repeated Start, clock stretching and master NACK. Random 7-bit addresses, some of them matching, are mixed with directed cases for the general call, buffer overflow, the 10-bit write-then-read sequence and each mode.

// File: rtl/i2c_slave_port.sv
`timescale 1ns/1ps
module i2c_slave_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam logic [3:0] M_S7 = 4'h1, M_S10 = 4'h2, M_S7I = 4'h5, M_S10I = 4'h6, M_FWM = 4'h8;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_BUF = 3'd2, A_ADRL = 3'd3, A_ADRH = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_ADR, S_ADR2, S_RX, S_TX, S_WAIT} st_t;

  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  assign scl_s = scl_sy[SYNC_STAGES-1];
  assign sda_s = sda_sy[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;

  logic       ctrl_en;
  logic [3:0] mode;
  logic [7:0] own_lo, buf_q, sr, txsr;
  logic [1:0] own_hi;
  logic       bf, sta_f, sto_f, rw_f, data_f, irq_f;
  logic       ack_drv, out_en, stretch, nack_q, full10;
  logic [3:0] cnt;
  st_t        st;

  wire is10    = (mode == M_S10) || (mode == M_S10I);
  wire slave_on = (mode == M_S7) || (mode == M_S10) || (mode == M_S7I) || (mode == M_S10I);
  wire sp_irq  = (mode == M_S7I) || (mode == M_S10I) || (mode == M_FWM);
  wire active  = (st != S_IDLE) && (st != S_WAIT);

  wire m7  = (sr[7:1] == own_lo[6:0]) && (sr[7:1] != 7'd0);
  wire mhi = (sr[7:3] == 5'b11110) && (sr[2:1] == own_hi);
  wire mlo = (sr == own_lo);

  assign sda_oe = ctrl_en & (ack_drv | (out_en & ~txsr[7]));
  assign scl_oe = ctrl_en & stretch;
  assign irq    = irq_f;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {2'b00, ctrl_en, 1'b0, mode};
      A_STAT:  reg_rdata = {irq_f, stretch, 1'b0, data_f, rw_f, sto_f, sta_f, bf};
      A_BUF:   reg_rdata = buf_q;
      A_ADRL:  reg_rdata = own_lo;
      A_ADRH:  reg_rdata = {6'd0, own_hi};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;  mode <= 4'h0;  own_lo <= 8'h00;  own_hi <= 2'b00;
      buf_q <= 8'h00;   sr <= 8'h00;   txsr <= 8'hFF;
      bf <= 1'b0;  sta_f <= 1'b0;  sto_f <= 1'b0;  rw_f <= 1'b0;  data_f <= 1'b0;  irq_f <= 1'b0;
      ack_drv <= 1'b0;  out_en <= 1'b0;  stretch <= 1'b0;  nack_q <= 1'b0;  full10 <= 1'b0;
      cnt <= 4'd0;  st <= S_IDLE;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL: begin ctrl_en <= reg_wdata[5]; mode <= reg_wdata[3:0]; end
          A_STAT: if (reg_wdata[7]) irq_f <= 1'b0;
          A_BUF: begin
            buf_q <= reg_wdata;
            if (stretch) begin
              txsr    <= reg_wdata;
              out_en  <= 1'b1;
              stretch <= 1'b0;
            end
          end
          A_ADRL: own_lo <= reg_wdata;
          A_ADRH: own_hi <= reg_wdata[1:0];
          default: ;
        endcase
      end
      if (reg_rd && reg_addr == A_BUF) bf <= 1'b0;

      if (!ctrl_en) begin
        st <= S_IDLE;  cnt <= 4'd0;  ack_drv <= 1'b0;  out_en <= 1'b0;  stretch <= 1'b0;
        sta_f <= 1'b0;  sto_f <= 1'b0;  full10 <= 1'b0;
      end else if (start_c) begin
        sta_f <= 1'b1;  sto_f <= 1'b0;
        if (sp_irq) irq_f <= 1'b1;
        cnt <= 4'd0;  ack_drv <= 1'b0;  out_en <= 1'b0;  stretch <= 1'b0;
        st <= slave_on ? S_ADR : S_IDLE;
      end else if (stop_c) begin
        sto_f <= 1'b1;  sta_f <= 1'b0;
        if (sp_irq) irq_f <= 1'b1;
        cnt <= 4'd0;  ack_drv <= 1'b0;  out_en <= 1'b0;  stretch <= 1'b0;
        full10 <= 1'b0;  st <= S_IDLE;
      end else if (scl_rise && active) begin
        if (cnt < 4'd8) sr <= {sr[6:0], sda_s};
        else nack_q <= sda_s;
        cnt <= cnt + 4'd1;
      end else if (scl_fall && active) begin
        if (cnt == 4'd8) begin
          case (st)
            S_ADR: begin
              if (!is10) begin
                if (m7) begin
                  ack_drv <= 1'b1;  buf_q <= sr;  bf <= 1'b1;  irq_f <= 1'b1;
                  rw_f <= sr[0];  data_f <= 1'b0;
                  st <= sr[0] ? S_TX : S_RX;
                end else st <= S_WAIT;
              end else if (mhi && !sr[0]) begin
                ack_drv <= 1'b1;  buf_q <= sr;  bf <= 1'b1;  irq_f <= 1'b1;
                rw_f <= 1'b0;  data_f <= 1'b0;  full10 <= 1'b0;  st <= S_ADR2;
              end else if (mhi && sr[0] && full10) begin
                ack_drv <= 1'b1;  buf_q <= sr;  bf <= 1'b1;  irq_f <= 1'b1;
                rw_f <= 1'b1;  data_f <= 1'b0;  st <= S_TX;
              end else begin
                full10 <= 1'b0;  st <= S_WAIT;
              end
            end
            S_ADR2: begin
              if (mlo) begin
                ack_drv <= 1'b1;  buf_q <= sr;  bf <= 1'b1;  irq_f <= 1'b1;
                full10 <= 1'b1;  st <= S_RX;
              end else st <= S_WAIT;
            end
            S_RX: begin
              if (!bf) begin
                ack_drv <= 1'b1;  buf_q <= sr;  bf <= 1'b1;  irq_f <= 1'b1;  data_f <= 1'b1;
              end else st <= S_WAIT;
            end
            S_TX: out_en <= 1'b0;
            default: ;
          endcase
        end else if (cnt == 4'd9) begin
          ack_drv <= 1'b0;
          cnt <= 4'd0;
          if (st == S_TX) begin
            if (nack_q) st <= S_WAIT;
            else begin
              stretch <= 1'b1;  irq_f <= 1'b1;
            end
          end
        end else if (st == S_TX && cnt != 4'd0) begin
          txsr <= {txsr[6:0], 1'b1};
          if (cnt == 4'd7) data_f <= 1'b1;
        end
      end
    end
  end

  assert_released_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> (st == S_IDLE && !sda_oe && !scl_oe));

  assert_no_general_call_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && !is10 && st == S_ADR && scl_fall && cnt == 4'd8 && sr[7:1] == 7'd0) |=> !ack_drv);

  assert_start_stop_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sta_f && sto_f));

  assert_master_mode_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && mode == M_FWM && st == S_IDLE) |=> (st == S_IDLE && !ack_drv));

  assert_stretch_until_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stretch && ctrl_en && !start_c && !stop_c && !(reg_wr && reg_addr == A_BUF)) |=> stretch);

  assert_nack_ends_tx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && st == S_TX && scl_fall && cnt == 4'd9 && nack_q) |=> (st == S_WAIT && !stretch));
endmodule

// File: tb/i2c_slave_port_tb.sv
`timescale 1ns/1ps
module i2c_slave_port_tb;
  localparam int Q = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, irq;
  logic r_wr = 1'b0, r_rd = 1'b0;
  logic [2:0] r_addr = 3'd0;
  logic [7:0] r_wdata = 8'd0, rdata;
  wire scl_ln = m_scl & ~scl_oe;
  wire sda_ln = m_sda & ~sda_oe;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  i2c_slave_port u_dut (.clk(clk), .rst_n(rst_n), .scl_i(scl_ln), .sda_i(sda_ln),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(r_wr), .reg_rd(r_rd), .reg_addr(r_addr),
    .reg_wdata(r_wdata), .reg_rdata(rdata), .irq(irq));

  function automatic bit exp_ack7(input logic [7:0] b, input logic [6:0] own);
    return (b[7:1] == own) && (b[7:1] != 7'd0);
  endfunction

  function automatic bit exp_ack10hi(input logic [7:0] b, input logic [1:0] hi);
    return (b[7:3] == 5'b11110) && (b[2:1] == hi);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    r_addr = a; r_wdata = d; r_wr = 1'b1;
    @(posedge clk); #1;
    r_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    r_addr = a; r_rd = 1'b1;
    #0.5 d = rdata;
    @(posedge clk); #1;
    r_rd = 1'b0;
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; wq();
    m_scl = 1'b1;
    while (scl_ln == 1'b0) @(posedge clk);
    #1; wq();
    s = sda_ln; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic m_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic m_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s);
    acked = (s == 1'b0);
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(~ack, s);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] d;
    bit a;
    void'($urandom(32'd4711));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(3'd1, d);
    chk(d == 8'h00 && !irq && !sda_oe && !scl_oe, "R5 reset", d, 0);

    wr(3'd3, 8'h3A); wr(3'd0, 8'h01);
    m_start(); send_byte(8'h74, a);
    chk(!a && !sda_oe, "R1 disabled no ack", a, 0);
    m_stop();

    wr(3'd0, 8'h21);
    m_start();
    rd(3'd1, d); chk(d[1] && !d[2], "R5 start bit", d, 8'h02);
    send_byte(8'h74, a); chk(a, "R2 own address ack", a, 1);
    rd(3'd1, d); chk(d[0] && d[7] && irq, "R2 bf irq", d, 8'h81);
    rd(3'd2, d); chk(d == 8'h74, "R2 buffer", d, 8'h74);
    wr(3'd1, 8'h80);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] v = 8'($urandom);
      send_byte(v, a); chk(a, "R2 data ack", a, 1);
      rd(3'd2, d); chk(d == v, "R2 data byte", d, v);
    end
    wr(3'd1, 8'h80);
    m_stop();
    rd(3'd1, d); chk(d[2] && !d[1], "R5 stop bit", d, 8'h04);
    chk(!irq, "R6 no start/stop irq in mode 1", irq, 0);

    m_start(); send_byte(8'h74, a);
    send_byte(8'h55, a); chk(!a, "R12 overflow nack", a, 0);
    rd(3'd2, d); chk(d == 8'h74, "R12 buffer kept", d, 8'h74);
    m_stop();

    for (int k = 0; k < 10; k++) begin
      logic [6:0] ad = ($urandom % 4 == 0) ? 7'h3A : 7'($urandom);
      bit e = exp_ack7({ad, 1'b0}, 7'h3A);
      m_start(); send_byte({ad, 1'b0}, a);
      chk(a == e, "R3 random address", a, e);
      if (e) begin
        rd(3'd2, d);
        send_byte(8'hC3, a); chk(a, "R2 random data ack", a, 1);
        rd(3'd2, d); chk(d == 8'hC3, "R2 random data", d, 8'hC3);
      end else begin
        send_byte(8'h00, a); chk(!a, "R3 following byte ignored", a, 0);
        rd(3'd1, d); chk(!d[0], "R3 buffer untouched", d, 0);
      end
      m_stop();
    end

    wr(3'd3, 8'h00);
    m_start(); send_byte(8'h00, a); chk(!a, "R4 general call nack", a, 0);
    m_stop();

    wr(3'd3, 8'h3A); wr(3'd0, 8'h25); wr(3'd1, 8'h80);
    m_start(); chk(irq, "R6 start irq", irq, 1);
    wr(3'd1, 8'h80); m_stop(); chk(irq, "R6 stop irq", irq, 1);
    wr(3'd1, 8'h80);

    wr(3'd0, 8'h28);
    m_start(); chk(irq, "R7 start irq in master mode", irq, 1);
    send_byte(8'h74, a); chk(!a, "R7 no ack in master mode", a, 0);
    m_stop();

    wr(3'd4, 8'h02); wr(3'd3, 8'h5C); wr(3'd0, 8'h22); wr(3'd1, 8'h80);
    m_start(); send_byte(8'hF4, a);
    chk(a == exp_ack10hi(8'hF4, 2'b10), "R8 first byte ack", a, 1);
    rd(3'd2, d);
    send_byte(8'h5D, a); chk(!a, "R8 wrong low byte", a, 0);
    m_stop();
    m_start(); send_byte(8'hF6, a); chk(!a, "R8 wrong high bits", a, 0);
    m_stop();
    m_start(); send_byte(8'hF4, a); rd(3'd2, d);
    send_byte(8'h5C, a); chk(a, "R8 low byte ack", a, 1);
    rd(3'd2, d);
    send_byte(8'h9E, a); chk(a, "R8 data ack", a, 1);
    rd(3'd2, d); chk(d == 8'h9E, "R8 data", d, 8'h9E);

    m_start(); send_byte(8'hF5, a); chk(a, "R9 read address ack", a, 1);
    rd(3'd1, d); chk(d[3], "R9 read bit", d, 8'h08);
    repeat (40) @(posedge clk); #1;
    chk(scl_oe, "R10 clock held", scl_oe, 1);
    rd(3'd2, d); wr(3'd2, 8'hA5);
    recv_byte(1'b1, d); chk(d == 8'hA5, "R10 tx byte msb first", d, 8'hA5);
    chk(scl_oe, "R10 held after ack", scl_oe, 1);
    wr(3'd2, 8'h3C);
    recv_byte(1'b0, d); chk(d == 8'h3C, "R10 second tx byte", d, 8'h3C);
    repeat (40) @(posedge clk); #1;
    chk(!scl_oe && !sda_oe, "R11 released after nack", {scl_oe, sda_oe}, 0);
    m_stop();

    wr(3'd0, 8'h01);
    repeat (4) @(posedge clk); #1;
    chk(!scl_oe && !sda_oe, "R1 pins released", {scl_oe, sda_oe}, 0);
    summary();
  end
endmodule